// File: doc/BRIEF.md
# Locked Indexed Configuration Register Bank

This block holds the configuration registers of a legacy disk-interface controller and exposes them through a byte-wide I/O port bus. Three port addresses are involved. A strapped base port holds a lock gate. An index port sits at base+4, and a data port sits at base+8. A host first writes an unlock code to the base port and reads it back to confirm the bank is present. It then writes a register number to the index port and reads or writes that register through the data port. Finally it writes any other value to the base port, which locks the bank again.

The bank has three kinds of storage. Register 0 is a read-only identification byte. Register 1 is a read/write configuration byte whose first write marks initialization as complete. Sixteen timing bytes give four per drive for four drives. The timing bytes are also driven out in parallel, so a neighbouring strobe generator can use them without going through the port bus.

Host accesses arrive as requests on a valid/ready channel. Reads return one byte each on a valid/ready response channel. A read response stays on the response channel until the host takes it. While a response is waiting and not taken, no new request is accepted. Writes produce no response.

Top module: `cfgport`

## Requirements
- R1: The base port address is chosen by `base_sel`: 0 selects 0x074, 1 selects 0x0F4, 2 selects 0x034 and 3 selects 0x0E4. Accesses to the other three candidate addresses have no effect on the bank.
- R2: A write of a value from 0x30 to 0x33 to the base port opens the bank. While the bank is open, a read of the base port returns that same code. While it is closed, a read of the base port returns 0x00.
- R3: A write of any value outside 0x30..0x33 to the base port closes the bank.
- R4: While open, the index port is at base+4 and the data port is at base+8, and a data access acts on the register last written to the index port. While closed, writes to the index and data ports are ignored and reads of them return 0xFF. A read of any undecoded address returns 0xFF.
- R5: Register 0 reads as 0x5 in bits 7:4 and the parameter `REV` (default 0x3) in bits 3:0, giving 0x53 by default. Writes to it have no effect.
- R6: Timing slot k (k = 0..3) of drive d uses these register indices. Drive 0 uses 0x03, 0x26, 0x04, 0x27. Drive 1 uses 0x05, 0x28, 0x06, 0x29. Drive 2 uses 0x2B, 0x30, 0x2C, 0x31. Drive 3 uses 0x2D, 0x32, 0x2E, 0x33. Slot k of drive d appears on `drv_timing[(d*4+k)*8 +: 8]` one cycle after its write is accepted.
- R7: A read of the index port returns the index latch. The exception is a latch holding 0x01: then the read returns 0x00 with bit 0 replaced by the init flag. The init flag is set by the first accepted write to register 0x01 while the bank is open.
- R8: Register 0x01 is a read/write byte. Reads of unimplemented indices return 0x00, and writes to them have no effect.
- R9: After reset the bank is closed, the index latch, register 0x01, the init flag and all timing bytes are zero, and no response is pending.
- R10: A request is accepted when `req_valid` and `req_ready` are both high. Each accepted read raises `rsp_valid` on the next cycle. `rsp_valid` and `rsp_data` hold until `rsp_ready` is high. `req_ready` is low exactly while a response is valid and not being taken. An accepted write never produces a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sel | input | 2 | Strap choosing the base port address |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 10 | I/O port address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Host takes the read data |
| rsp_data | output | 8 | Read data |
| drv_timing | output | 128 | All sixteen timing bytes, drive-major, slot-minor |

## Verification
The assertions check the response handshake on every cycle. A stalled response must block new requests and hold its data, and accepted writes must never produce a response. Also checked on every cycle: the timing outputs stay frozen while the bank is locked, a base-port read echoes the open code, a locked data-port read floats to 0xFF, and the identification nibble always reads 0x5. The bank's contents can only be shown by the bench's scenarios, which compare every read against a reference model. These contents include the drive-to-index mapping and its parallel outputs, the init flag on the index port, reads of unimplemented registers, the effect of the strap, and locking through a foreign value.

// File: rtl/cfgport_pkg.sv
`timescale 1ns/1ps
package cfgport_pkg;

  typedef enum logic [1:0] {
    PORT_NONE  = 2'd0,
    PORT_BASE  = 2'd1,
    PORT_INDEX = 2'd2,
    PORT_DATA  = 2'd3
  } port_e;

  localparam int INDEX_OFS = 4;
  localparam int DATA_OFS  = 8;

  // Strap value to base port address.
  function automatic logic [9:0] strap_base(input logic [1:0] sel);
    case (sel)
      2'd0:    return 10'h074;
      2'd1:    return 10'h0F4;
      2'd2:    return 10'h034;
      default: return 10'h0E4;
    endcase
  endfunction

  // Register index of timing slot `slot` for drive `drive`; the slot order
  // is what the strobe generator consumes, so it is kept fixed.
  function automatic logic [7:0] timing_index(input int drive, input int slot);
    logic [7:0] lo_base;
    logic [7:0] hi_base;
    logic [7:0] step;
    lo_base = (drive >= 2) ? 8'h2B : 8'h03;
    hi_base = (drive >= 2) ? 8'h30 : 8'h26;
    step    = 8'(2 * (drive % 2));
    case (slot)
      0:       return lo_base + step;
      1:       return hi_base + step;
      2:       return lo_base + step + 8'd1;
      default: return hi_base + step + 8'd1;
    endcase
  endfunction

endpackage

// File: rtl/cfgport_decode.sv
`timescale 1ns/1ps
module cfgport_decode
  import cfgport_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [1:0]        base_sel,
  input  logic [ADDR_W-1:0] addr,
  output port_e             kind
);

  logic [ADDR_W-1:0] base_addr;

  always_comb begin
    base_addr = ADDR_W'(strap_base(base_sel));
    kind      = PORT_NONE;
    if (addr == base_addr)
      kind = PORT_BASE;
    else if (addr == base_addr + ADDR_W'(INDEX_OFS))
      kind = PORT_INDEX;
    else if (addr == base_addr + ADDR_W'(DATA_OFS))
      kind = PORT_DATA;
  end

endmodule

// File: rtl/cfgport_gate.sv
`timescale 1ns/1ps
module cfgport_gate #(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] CODE_LO = 8'h30,
  parameter logic [DATA_W-1:0] CODE_HI = 8'h33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              open_o,
  output logic [DATA_W-1:0] code_o
);

  logic is_code;

  assign is_code = (wdata >= CODE_LO) && (wdata <= CODE_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      code_o <= '0;
    end else if (base_wr) begin
      open_o <= is_code;
      code_o <= is_code ? wdata : '0;
    end
  end

endmodule

// File: rtl/cfgport_regs.sv
`timescale 1ns/1ps
module cfgport_regs
  import cfgport_pkg::*;
#(
  parameter int         NUM_DRIVES = 4,
  parameter int         SLOTS      = 4,
  parameter int         DATA_W     = 8,
  parameter logic [3:0] REV        = 4'h3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [DATA_W-1:0]                   idx,
  input  logic [DATA_W-1:0]                   wdata,
  output logic [DATA_W-1:0]                   rd_data,
  output logic                                init_flag,
  output logic [NUM_DRIVES*SLOTS*DATA_W-1:0]  timing_o
);

  localparam int NREG = NUM_DRIVES * SLOTS;
  localparam logic [DATA_W-1:0] IDX_ID  = '0;
  localparam logic [DATA_W-1:0] IDX_CFG = DATA_W'(1);

  logic [DATA_W-1:0] tim_q [NREG];
  logic [DATA_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) tim_q[r] <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < NREG; r++)
        if (idx == DATA_W'(timing_index(r / SLOTS, r % SLOTS)))
          tim_q[r] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      init_flag <= 1'b0;
    end else if (wr_en && idx == IDX_CFG) begin
      cfg_q     <= wdata;
      init_flag <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    if (idx == IDX_ID)
      rd_data = DATA_W'({4'h5, REV});
    else if (idx == IDX_CFG)
      rd_data = cfg_q;
    for (int r = 0; r < NREG; r++)
      if (idx == DATA_W'(timing_index(r / SLOTS, r % SLOTS)))
        rd_data = tim_q[r];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign timing_o[g*DATA_W +: DATA_W] = tim_q[g];
  end

endmodule

// File: rtl/cfgport.sv
`timescale 1ns/1ps
module cfgport
  import cfgport_pkg::*;
#(
  parameter int         ADDR_W     = 10,
  parameter int         DATA_W     = 8,
  parameter int         NUM_DRIVES = 4,
  parameter int         SLOTS      = 4,
  parameter logic [3:0] REV        = 4'h3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [1:0]                          base_sel,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic                                req_write,
  input  logic [ADDR_W-1:0]                   req_addr,
  input  logic [DATA_W-1:0]                   req_wdata,
  output logic                                rsp_valid,
  input  logic                                rsp_ready,
  output logic [DATA_W-1:0]                   rsp_data,
  output logic [NUM_DRIVES*SLOTS*DATA_W-1:0]  drv_timing
);

  localparam logic [DATA_W-1:0] FLOAT   = '1;
  localparam logic [DATA_W-1:0] IDX_CFG = DATA_W'(1);

  port_e             kind;
  logic              accept;
  logic              wr_acc;
  logic              bank_open;
  logic [DATA_W-1:0] bank_code;
  logic [DATA_W-1:0] index_q;
  logic [DATA_W-1:0] reg_rd;
  logic              init_flag;
  logic [DATA_W-1:0] rd_mux;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_acc    = accept && req_write;

  cfgport_decode #(.ADDR_W(ADDR_W)) u_decode (
    .base_sel (base_sel),
    .addr     (req_addr),
    .kind     (kind)
  );

  cfgport_gate #(.DATA_W(DATA_W)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .base_wr (wr_acc && kind == PORT_BASE),
    .wdata   (req_wdata),
    .open_o  (bank_open),
    .code_o  (bank_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      index_q <= '0;
    else if (wr_acc && bank_open && kind == PORT_INDEX)
      index_q <= req_wdata;
  end

  cfgport_regs #(
    .NUM_DRIVES (NUM_DRIVES),
    .SLOTS      (SLOTS),
    .DATA_W     (DATA_W),
    .REV        (REV)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_acc && bank_open && kind == PORT_DATA),
    .idx       (index_q),
    .wdata     (req_wdata),
    .rd_data   (reg_rd),
    .init_flag (init_flag),
    .timing_o  (drv_timing)
  );

  always_comb begin
    rd_mux = FLOAT;
    case (kind)
      PORT_BASE:  rd_mux = bank_open ? bank_code : '0;
      PORT_INDEX: if (bank_open)
                    rd_mux = (index_q == IDX_CFG) ? DATA_W'(init_flag) : index_q;
      PORT_DATA:  if (bank_open) rd_mux = reg_rd;
      default:    rd_mux = FLOAT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/cfgport_checker.sv
`timescale 1ns/1ps
module cfgport_checker
  import cfgport_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int TIM_W  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        base_sel,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [TIM_W-1:0]  drv_timing,
  input logic              bank_open,
  input logic [DATA_W-1:0] bank_code,
  input logic [DATA_W-1:0] index_q
);

  logic [ADDR_W-1:0] base_a;
  logic              rd_acc;
  logic              wr_acc;

  assign base_a = ADDR_W'(strap_base(base_sel));
  assign rd_acc = req_valid && req_ready && !req_write;
  assign wr_acc = req_valid && req_ready && req_write;

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R10
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !rsp_valid); // R10
  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid); // R10
  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_open |=> $stable(drv_timing)); // R4
  AST_BASE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && bank_open && req_addr == base_a) |=> rsp_data == $past(bank_code)); // R2
  AST_LOCKED_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !bank_open && req_addr == base_a + ADDR_W'(DATA_OFS)) |=> rsp_data == 8'hFF); // R4
  AST_ID_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && bank_open && index_q == '0 && req_addr == base_a + ADDR_W'(DATA_OFS))
      |=> rsp_data[7:4] == 4'h5); // R5

endmodule

bind cfgport cfgport_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .TIM_W  (NUM_DRIVES*SLOTS*DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .base_sel   (base_sel),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .drv_timing (drv_timing),
  .bank_open  (bank_open),
  .bank_code  (bank_code),
  .index_q    (index_q)
);

// File: tb/cfgport_bench.sv
`timescale 1ns/1ps
module cfgport_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   base_sel = 2'd0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [9:0]   req_addr = '0;
  logic [7:0]   req_wdata = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [7:0]   rsp_data;
  logic [127:0] drv_timing;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cfgport u_cfgport (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_sel   (base_sel),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_data   (rsp_data),
    .drv_timing (drv_timing)
  );

  // ---------------- reference model ----------------
  bit       m_open;
  bit [7:0] m_code, m_idx, m_cfg;
  bit       m_init;
  bit [7:0] m_tim [4][4];

  function automatic bit [9:0] base_of(input bit [1:0] s);
    bit [9:0] t [4] = '{10'h074, 10'h0F4, 10'h034, 10'h0E4};
    return t[s];
  endfunction

  function automatic bit [7:0] slot_idx(input int d, input int k);
    bit [7:0] t [4][4] = '{'{8'h03, 8'h26, 8'h04, 8'h27}, '{8'h05, 8'h28, 8'h06, 8'h29},
                           '{8'h2B, 8'h30, 8'h2C, 8'h31}, '{8'h2D, 8'h32, 8'h2E, 8'h33}};
    return t[d][k];
  endfunction

  function automatic bit [7:0] exp_reg(input bit [7:0] i);
    if (i == 8'h00) return 8'h53;
    if (i == 8'h01) return m_cfg;
    for (int d = 0; d < 4; d++)
      for (int k = 0; k < 4; k++)
        if (slot_idx(d, k) == i) return m_tim[d][k];
    return 8'h00;
  endfunction

  function automatic bit [7:0] exp_read(input bit [9:0] a);
    bit [9:0] b = base_of(base_sel);
    if (a == b) return m_open ? m_code : 8'h00;
    if (a == b + 10'd4) return !m_open ? 8'hFF : (m_idx == 8'h01 ? {7'b0, m_init} : m_idx);
    if (a == b + 10'd8) return m_open ? exp_reg(m_idx) : 8'hFF;
    return 8'hFF;
  endfunction

  function automatic void model_write(input bit [9:0] a, input bit [7:0] v);
    bit [9:0] b = base_of(base_sel);
    if (a == b) begin
      m_open = (v >= 8'h30 && v <= 8'h33);
      m_code = m_open ? v : 8'h00;
    end else if (a == b + 10'd4 && m_open) begin
      m_idx = v;
    end else if (a == b + 10'd8 && m_open) begin
      if (m_idx == 8'h01) begin m_cfg = v; m_init = 1'b1; end
      for (int d = 0; d < 4; d++)
        for (int k = 0; k < 4; k++)
          if (slot_idx(d, k) == m_idx) m_tim[d][k] = v;
    end
  endfunction

  function automatic void model_reset();
    m_open = 0; m_code = 0; m_idx = 0; m_cfg = 0; m_init = 0;
    for (int d = 0; d < 4; d++)
      for (int k = 0; k < 4; k++) m_tim[d][k] = 0;
  endfunction

  // ---------------- helpers ----------------
  task automatic chk(input string rq, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", rq, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input bit [9:0] a, input bit [7:0] v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
    @(negedge clk);
    req_valid = 1'b0;
    model_write(a, v);
  endtask

  task automatic rd(input bit [9:0] a, input string rq);
    bit [7:0] e;
    e = exp_read(a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({rq, " rsp_valid"}, 8'(rsp_valid), 8'h01);
    chk(rq, rsp_data, e);
  endtask

  task automatic chk_timing(input string rq);
    for (int d = 0; d < 4; d++)
      for (int k = 0; k < 4; k++)
        chk(rq, drv_timing[(d*4+k)*8 +: 8], m_tim[d][k]);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    bit [9:0] b;
    void'($urandom(32'h5EED_0042));
    do_reset();
    b = base_of(2'd0);

    // R9 reset state
    chk("R9 rsp_valid", 8'(rsp_valid), 8'h00);
    chk("R9 req_ready", 8'(req_ready), 8'h01);
    chk_timing("R9 timing");

    // R4 locked bank, R2 locked base read
    rd(b + 10'd8, "R4 locked data");
    rd(b + 10'd4, "R4 locked index");
    rd(b, "R2 locked base");
    wr(b + 10'd4, 8'h03);
    wr(b + 10'd8, 8'hAB);
    chk_timing("R4 locked write");

    // R1 foreign address does not open
    wr(base_of(2'd1), 8'h30);
    rd(b, "R1 foreign base");
    rd(10'h0F4 + 10'd8, "R1 undecoded");

    // R2 open and echo
    wr(b, 8'h31);
    rd(b, "R2 echo");
    rd(b + 10'd8, "R4 index reset zero");

    // R5 identification
    wr(b + 10'd4, 8'h00);
    rd(b + 10'd8, "R5 id");
    wr(b + 10'd8, 8'hAA);
    rd(b + 10'd8, "R5 id read-only");

    // R7 init flag, R8 config byte
    wr(b + 10'd4, 8'h01);
    rd(b + 10'd4, "R7 flag before init");
    wr(b + 10'd8, 8'h0F);
    rd(b + 10'd4, "R7 flag after init");
    rd(b + 10'd8, "R8 config");
    wr(b + 10'd4, 8'h2A);
    rd(b + 10'd4, "R7 index latch");

    // R8 unimplemented
    wr(b + 10'd4, 8'h10);
    wr(b + 10'd8, 8'h77);
    rd(b + 10'd8, "R8 unimplemented");

    // R6 map and parallel outputs
    for (int d = 0; d < 4; d++)
      for (int k = 0; k < 4; k++) begin
        wr(b + 10'd4, slot_idx(d, k));
        wr(b + 10'd8, 8'(8'h10 * d + k + 1));
      end
    chk_timing("R6 map");
    wr(b + 10'd4, slot_idx(2, 1));
    rd(b + 10'd8, "R6 readback");

    // R3 close with foreign value
    wr(b, 8'h34);
    rd(b + 10'd4, "R3 closed index");
    rd(b, "R3 closed base");

    // R10 back-pressure
    wr(b, 8'h33);
    wr(b + 10'd4, 8'h2B);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = b;
    @(negedge clk);
    chk("R10 first rsp", rsp_data, 8'h33);
    req_addr = b + 10'd4;
    chk("R10 stall ready", 8'(req_ready), 8'h00);
    repeat (2) @(negedge clk);
    chk("R10 held valid", 8'(rsp_valid), 8'h01);
    chk("R10 held data", rsp_data, 8'h33);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 second rsp", rsp_data, 8'h2B);
    @(negedge clk);
    chk("R10 drained", 8'(rsp_valid), 8'h00);

    // R1 other strap
    base_sel = 2'd2;
    do_reset();
    b = base_of(2'd2);
    wr(base_of(2'd0), 8'h30);
    rd(b, "R1 strap closed");
    wr(b, 8'h32);
    rd(b, "R1 strap open");

    // constrained random traffic
    for (int n = 0; n < 600; n++) begin
      int unsigned p = $urandom % 100;
      bit [9:0] a;
      bit [7:0] v;
      if (p < 10)      a = b;
      else if (p < 40) a = b + 10'd4;
      else if (p < 95) a = b + 10'd8;
      else             a = b + 10'd1;
      if (a == b)
        v = ($urandom % 4 != 0) ? 8'(8'h30 + $urandom % 4) : 8'($urandom);
      else if (a == b + 10'd4)
        v = ($urandom % 4 != 0) ? slot_idx($urandom % 4, $urandom % 4) : 8'($urandom % 3);
      else
        v = 8'($urandom);
      if ($urandom % 2) wr(a, v);
      else rd(a, "R4 random read");
      if (n % 50 == 49) chk_timing("R6 random timing");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule